// File: doc/BRIEF.md
# USB Start-of-Frame Token Generator

This block keeps a USB host port's frame clock. It counts bit-rate ticks and, once per frame interval, sends a start-of-frame token onto the D+/D- pair. The token carries an 11-bit frame number that advances by one with every token sent. It also carries a 5-bit CRC computed over that number. The token is NRZI encoded and bit stuffed, and it ends with a single-ended-zero end of packet. After the packet the block releases the line drivers.

The surrounding port logic supplies a one-cycle `bit_tick` pulse for each bit time and raises `enable` while the port is operational. All line changes are aligned to those ticks. The low-speed line polarity is the default. A parameter selects the full-speed polarity instead.

A frame request that arrives while a token is still on the line is discarded, not queued. This only matters when the frame interval is shorter than a token.

Top module: `sof_token_gen`

## Requirements
- R1: During and right after reset, `oe` is 0 and the line shows the idle J state (`dp`=0, `dm`=1 with the default low-speed polarity).
- R2: While `enable` is low the interval counter is held at zero and no token starts. With `enable` high, a token start is attempted on every FRAME_TICKS-th tick (default 1500), the first one on the FRAME_TICKS-th tick after `enable` rises. `oe` rises at the attempting tick.
- R3: A start attempt made while a token is still being sent is dropped. The next attempt is one full interval later, and no frame number is skipped.
- R4: Each token carries 32 unstuffed bits, sent one per tick starting at the start tick. The first 8 bits are the sync field: seven 0 bits and then a 1.
- R5: Bits 8 to 15 are the PID byte 8'hA5, sent LSB first. This byte is the code 4'b0101 in the low nibble and its complement in the high nibble.
- R6: Bits 16 to 26 are the frame number, sent LSB first. It is 0 in the first token after reset, rises by one per token actually sent, and wraps from 2047 to 0.
- R7: Bits 27 to 31 hold the CRC5 of the frame number, sent MSB first. The CRC uses x^5+x^2+1, starts from all ones, takes the frame bits LSB first, and is inverted before it is sent.
- R8: NRZI coding is used. A 0 bit toggles between J and K and a 1 bit holds the level. Each token starts from J, and the line shows J whenever `oe` is low.
- R9: After six consecutive 1 bits, counted across field boundaries, a 0 bit is inserted. No stuffed bit is placed in front of the end of packet.
- R10: The end of packet is two ticks of SE0 followed by one tick of J. `oe` falls at the next tick, so a token occupies 35 + (stuffed bits) ticks. `dp`, `dm` and `oe` change only on tick edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Frame timing runs while high |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| dp | output | 1 | D+ drive level |
| dm | output | 1 | D- drive level |
| oe | output | 1 | Line driver enable |

## Verification
The hardest situations to reach are the dropped start request and the frame-number wrap. A drop needs a token to be still on the line when the next interval ends. A wrap needs more than two thousand tokens.

The bench builds the block with a 36-tick interval. A token with no stuffed bits then fits inside the interval, but a token that needed stuffing collides with the next attempt. Frame numbers ending in five 1 bits give such a collision within the first few dozen frames.

After a randomly paced opening phase, ticks are issued on every clock. This carries the frame number past 2047 within the cycle budget. Every token is decoded from the wire and compared field by field with values worked out in the bench.

// File: rtl/sof_pkg.sv
package sof_pkg;
   localparam int SYNC_W  = 8;
   localparam int PID_W   = 8;
   localparam int FRAME_W = 11;
   localparam int CRC_W   = 5;
   localparam int TOKEN_W = SYNC_W + PID_W + FRAME_W + CRC_W;

   localparam logic [3:0]         PID_SOF   = 4'b0101;
   localparam logic [SYNC_W-1:0]  SYNC_PAT  = 8'h80;
   localparam logic [CRC_W-1:0]   CRC_POLY  = 5'b00101;
   localparam int                 STUFF_RUN = 6;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_BITS,
      TX_SE0A,
      TX_SE0B,
      TX_JEND
   } tx_state_e;
endpackage

// File: rtl/sof_frame_timer.sv
module sof_frame_timer #(
   parameter int TICKS = 1500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic bit_tick,
   output logic fire
);
   localparam int          CW   = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   if (TICKS < 2) begin : g_bad_ticks
      $error("sof_frame_timer: TICKS must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         cnt_q <= '0;
      end else if (bit_tick) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + CW'(1);
      end
   end

   assign fire = enable && bit_tick && (cnt_q == LAST);

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cnt_q == '0));
endmodule

// File: rtl/sof_crc5.sv
module sof_crc5 #(
   parameter int               DATA_W = 11,
   parameter int               CRC_W  = 5,
   parameter logic [CRC_W-1:0] POLY   = 5'b00101
) (
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  field   // bit 0 is the first bit on the wire
);
   if (CRC_W < 2) begin : g_bad_width
      $error("sof_crc5: CRC_W must be at least 2");
   end

   logic [CRC_W-1:0] rem;

   always_comb begin
      logic [CRC_W-1:0] r;
      logic             fb;
      r = '1;
      for (int i = 0; i < DATA_W; i++) begin
         fb = r[CRC_W-1] ^ data[i];
         r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      rem = ~r;
   end

   // Remainder leaves MSB first: reverse it into shift order.
   for (genvar g = 0; g < CRC_W; g++) begin : g_rev
      assign field[g] = rem[CRC_W-1-g];
   end
endmodule

// File: rtl/sof_line_tx.sv
module sof_line_tx
   import sof_pkg::*;
#(
   parameter int PAYLOAD_W = 32,
   parameter int RUN_MAX   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_tick,
   input  logic                 start,
   input  logic [PAYLOAD_W-1:0] payload,
   output logic                 busy,
   output logic                 lvl_j,    // 1: J, 0: K
   output logic                 se0,
   output logic                 oe
);
   localparam int IW = $clog2(PAYLOAD_W + 1);
   localparam int SW = (PAYLOAD_W > 1) ? $clog2(PAYLOAD_W) : 1;
   localparam int RW = $clog2(RUN_MAX + 1);

   if (RUN_MAX < 1) begin : g_bad_run
      $error("sof_line_tx: RUN_MAX must be positive");
   end

   tx_state_e              st_q;
   logic [IW-1:0]          idx_q;
   logic [RW-1:0]          ones_q;
   logic [PAYLOAD_W-1:0]   pay_q;
   logic                   lvl_q, se0_q, oe_q;
   logic                   cur_bit;

   assign cur_bit = pay_q[idx_q[SW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= TX_IDLE;
         idx_q  <= '0;
         ones_q <= '0;
         pay_q  <= '0;
         lvl_q  <= 1'b1;
         se0_q  <= 1'b0;
         oe_q   <= 1'b0;
      end else if (bit_tick) begin
         case (st_q)
            TX_IDLE: begin
               if (start) begin
                  pay_q  <= payload;
                  oe_q   <= 1'b1;
                  lvl_q  <= payload[0] ? lvl_q : ~lvl_q;
                  ones_q <= payload[0] ? RW'(1) : '0;
                  idx_q  <= IW'(1);
                  st_q   <= TX_BITS;
               end
            end
            TX_BITS: begin
               if (idx_q == IW'(PAYLOAD_W)) begin
                  se0_q <= 1'b1;
                  st_q  <= TX_SE0A;
               end else if (ones_q == RW'(RUN_MAX)) begin
                  lvl_q  <= ~lvl_q;
                  ones_q <= '0;
               end else begin
                  lvl_q  <= cur_bit ? lvl_q : ~lvl_q;
                  ones_q <= cur_bit ? ones_q + RW'(1) : '0;
                  idx_q  <= idx_q + IW'(1);
               end
            end
            TX_SE0A: st_q <= TX_SE0B;
            TX_SE0B: begin
               se0_q <= 1'b0;
               lvl_q <= 1'b1;
               st_q  <= TX_JEND;
            end
            default: begin
               oe_q   <= 1'b0;
               idx_q  <= '0;
               ones_q <= '0;
               st_q   <= TX_IDLE;
            end
         endcase
      end
   end

   assign busy  = (st_q != TX_IDLE);
   assign lvl_j = lvl_q;
   assign se0   = se0_q;
   assign oe    = oe_q;

   a_r8_idle_is_j: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_q |-> (lvl_q && !se0_q));

   a_r9_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= RW'(RUN_MAX));

   a_r10_j_after_se0: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(se0_q) |-> (lvl_q && oe_q));

   a_r10_release_from_j: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_q) |-> $past(lvl_q && !se0_q));
endmodule

// File: rtl/sof_token_gen.sv
module sof_token_gen
   import sof_pkg::*;
#(
   parameter int FRAME_TICKS = 1500,
   parameter int LOW_SPEED   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic bit_tick,
   output logic dp,
   output logic dm,
   output logic oe
);
   if (LOW_SPEED != 0 && LOW_SPEED != 1) begin : g_bad_speed
      $error("sof_token_gen: LOW_SPEED must be 0 or 1");
   end
   if (TOKEN_W != SYNC_W + PID_W + FRAME_W + CRC_W) begin : g_bad_token
      $error("sof_token_gen: token width mismatch");
   end

   logic                 fire, busy, accept;
   logic                 lvl_j, se0, dp_j;
   logic [FRAME_W-1:0]   frame_q;
   logic [CRC_W-1:0]     crc_field;
   logic [TOKEN_W-1:0]   token;

   sof_frame_timer #(.TICKS(FRAME_TICKS)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .bit_tick (bit_tick),
      .fire     (fire)
   );

   sof_crc5 #(.DATA_W(FRAME_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .data  (frame_q),
      .field (crc_field)
   );

   assign accept = fire && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n)      frame_q <= '0;
      else if (accept) frame_q <= frame_q + FRAME_W'(1);
   end

   assign token = {crc_field, frame_q, ~PID_SOF, PID_SOF, SYNC_PAT};

   sof_line_tx #(.PAYLOAD_W(TOKEN_W), .RUN_MAX(STUFF_RUN)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .start    (fire),
      .payload  (token),
      .busy     (busy),
      .lvl_j    (lvl_j),
      .se0      (se0),
      .oe       (oe)
   );

   if (LOW_SPEED == 1) begin : g_low
      assign dp_j = 1'b0;
   end else begin : g_full
      assign dp_j = 1'b1;
   end

   assign dp = se0 ? 1'b0 : (lvl_j ? dp_j : ~dp_j);
   assign dm = se0 ? 1'b0 : (lvl_j ? ~dp_j : dp_j);

   a_r10_tick_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable({dp, dm, oe}));

   a_r6_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_q) |-> (frame_q == $past(frame_q) + FRAME_W'(1)));

   a_r3_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && busy) |=> $stable(frame_q));

   a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !$rose(oe));
endmodule

// File: tb/sof_token_gen_bench.sv
module sof_token_gen_bench;
   localparam int N = 36;

   logic clk = 1'b0;
   logic rst_n, enable, bit_tick;
   logic dp, dm, oe;

   always #2 clk = ~clk;

   sof_token_gen #(.FRAME_TICKS(N), .LOW_SPEED(1)) u_sof_token_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick),
      .dp(dp), .dm(dm), .oe(oe)
   );

   int checks = 0, errors = 0;
   int tick_no = 0, tcnt = 0, drops = 0, pkts = 0, wraps = 0;
   bit dec_active = 0, prev_j = 1, j_seen = 0, done = 0;
   int nb = 0, ones = 0, stuffs = 0, se0_cnt = 0, start_tick = 0;
   logic [31:0] pkt_bits;
   logic [10:0] exp_frame = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [4:0] crc_field(input logic [10:0] f);
      logic [4:0] c;
      logic fb;
      c = 5'h1F;
      for (int i = 0; i < 11; i++) begin
         fb = c[4] ^ f[i];
         c  = {c[3:0], 1'b0};
         if (fb) c = c ^ 5'h05;
      end
      c = ~c;
      return {c[0], c[1], c[2], c[3], c[4]};
   endfunction

   task automatic data_bit(input bit lvl);
      bit b;
      b = (lvl == prev_j);
      prev_j = lvl;
      if (ones == 6) begin
         chk(b == 1'b0, "R9", "stuffed bit value", b, 0);
         stuffs++;
         ones = 0;
      end else begin
         if (nb < 32) pkt_bits[nb] = b;
         nb++;
         ones = b ? ones + 1 : 0;
      end
   endtask

   task automatic finish_packet();
      chk(j_seen, "R10", "J before release", j_seen, 1);
      chk(!dp && dm, "R8", "idle J after release", {dp, dm}, 1);
      chk(nb == 32, "R4", "unstuffed bit count", nb, 32);
      chk(tick_no - start_tick == 35 + stuffs, "R10", "token occupancy",
          tick_no - start_tick, 35 + stuffs);
      chk(pkt_bits[7:0] == 8'h80, "R4", "sync field", pkt_bits[7:0], 8'h80);
      chk(pkt_bits[15:8] == 8'hA5, "R5", "PID byte", pkt_bits[15:8], 8'hA5);
      chk(pkt_bits[26:16] == exp_frame, "R6", "frame number",
          pkt_bits[26:16], exp_frame);
      chk(pkt_bits[31:27] == crc_field(exp_frame), "R7", "CRC5 field",
          pkt_bits[31:27], crc_field(exp_frame));
      if (pkts > 0 && exp_frame == 11'd0) wraps++;
      exp_frame = exp_frame + 11'd1;
      pkts++;
   endtask

   task automatic observe();
      bit se0, lvl;
      se0 = !dp && !dm;
      lvl = !dp && dm;
      if (!dec_active) begin
         if (oe) begin
            dec_active = 1; start_tick = tick_no; prev_j = 1;
            nb = 0; ones = 0; stuffs = 0; se0_cnt = 0; j_seen = 0;
            pkt_bits = '0;
            data_bit(lvl);
         end
      end else if (!oe) begin
         finish_packet();
         dec_active = 0;
      end else if (se0) begin
         if (se0_cnt == 0) chk(nb == 32, "R9", "no stuff before EOP", nb, 32);
         se0_cnt++;
      end else if (se0_cnt > 0) begin
         if (j_seen) chk(0, "R10", "extra bit after EOP J", 1, 0);
         else begin
            chk(se0_cnt == 2, "R10", "SE0 bit times", se0_cnt, 2);
            chk(lvl, "R10", "J after SE0", lvl, 1);
            j_seen = 1;
         end
      end else begin
         data_bit(lvl);
      end
   endtask

   task automatic drive_tick(input int unsigned idle_cycles);
      bit fire, was_active, exp_start, started;
      bit_tick = 0;
      repeat (idle_cycles) @(negedge clk);
      fire = 0;
      if (enable) begin
         if (tcnt == N - 1) begin fire = 1; tcnt = 0; end
         else tcnt++;
      end else tcnt = 0;
      was_active = dec_active;
      exp_start  = fire && !was_active;
      if (fire && was_active) drops++;
      bit_tick = 1;
      @(negedge clk);
      bit_tick = 0;
      tick_no++;
      started = !was_active && oe;
      observe();
      if (exp_start || started)
         chk(exp_start == started, "R2", "token start on interval tick",
             started, exp_start);
   endtask

   task automatic end_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      end_run();
   end

   initial begin
      bit paused;
      void'($urandom(32'd1234));
      paused = 0;
      rst_n = 0; enable = 0; bit_tick = 0;
      repeat (3) @(negedge clk);
      chk(!oe && !dp && dm, "R1", "state in reset", {oe, dp, dm}, 3'b001);
      rst_n = 1;
      @(negedge clk);
      chk(!oe && !dp && dm, "R1", "state after reset", {oe, dp, dm}, 3'b001);

      // R2: disabled, ticks must not start a token
      for (int i = 0; i < 50; i++) drive_tick($urandom_range(0, 3));
      chk(pkts == 0 && !oe, "R2", "no token while disabled", pkts, 0);

      enable = 1;
      while (pkts < 60) begin
         if (pkts == 30 && !dec_active && !paused) begin
            paused = 1;
            enable = 0;
            tcnt = 0;
            for (int i = 0; i < int'($urandom_range(5, 40)); i++)
               drive_tick($urandom_range(0, 3));
            enable = 1;
         end
         drive_tick($urandom_range(0, 3));
      end

      // Back-to-back ticks to carry the frame number past its wrap
      while (pkts < 2060) drive_tick(0);

      chk(drops > 0, "R3", "dropped start attempts seen", drops, 1);
      chk(wraps > 0, "R6", "frame number wrapped to 0", wraps, 1);
      end_run();
   end
endmodule